// File: doc/BRIEF.md
# Expansion Audio Register and Pulse-Timer Unit

This block sits on the write side of an 8-bit CPU bus. It decodes a small window of addresses starting at 0x5000. It holds the control state for two square-wave tone channels and for a raw 8-bit PCM level. For each square channel it runs an 11-bit period countdown, paced by the audio tick, and that countdown advances a 3-bit, eight-position duty sequencer. Later stages use the sequencer position to index a duty pattern.

Each channel also has a 5-bit length count. A write to the third channel register loads the count. An external length clock pulse wears it down. A global enable register can zero it at once. The PCM path shows the stored amplitude only while its active-low enable bit is clear. A one-cycle strobe tells the mixer that one of the outputs has moved. The block has no sweep units. Register reads, duty tables, envelopes and mixing are handled elsewhere.

Top module: `xaud_unit`

## Requirements
- R1: Writes to addresses below 0x5000, and to addresses in the window with no assigned role (including the sweep slots 0x5001 and 0x5005), change no output and raise no strobe.
- R2: Channel 0 is controlled at 0x5000 (control), 0x5002 (period low byte) and 0x5003 (period bits 10:8 in data bits 2:0, length load in data bits 7:3). Channel 1 uses 0x5004, 0x5006 and 0x5007 in the same roles. The period is 11 bits wide.
- R3: On every audio tick each channel's timer counts down by one. A tick that finds the timer at 1 reloads it with (period+1)*2 and advances the sequencer by one, modulo 8. Steps are therefore exactly 2*(period+1) ticks apart.
- R4: After reset both timers hold 1, so the first tick steps both sequencers. Sequencers, length enables, length counts, PCM output and the strobe all reset to 0.
- R5: Bit 0 of a write to 0x5010 is an active-low PCM enable: 0 enables the output and 1 disables it. After reset the PCM path is disabled.
- R6: A write to 0x5011 stores the PCM amplitude. The PCM output equals the amplitude while enabled and 0 otherwise, and it is updated on a write to either 0x5010 or 0x5011.
- R7: In a write to 0x5015, data bit 0 sets channel 0's length enable and bit 1 sets channel 1's. A cleared enable forces that channel's length count to 0 on the same edge.
- R8: A write to a channel's third register returns its sequencer to 0. If that channel's length enable is set, the write also loads data bits 7:3 into the length count. Otherwise the count is not loaded.
- R9: On a length clock pulse a nonzero count decrements, unless the channel's halt bit (bit 5 of its control register) is set. A halted count holds its value.
- R10: A channel's length-active output is 1 exactly when its length count is nonzero.
- R11: The change strobe is high for the one cycle that follows any sequencer step or any write to 0x5010 or 0x5011, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| apu_tick | input | 1 | Audio tick that paces the channel timers |
| len_clk | input | 1 | Length-counter clock pulse |
| seq_pos | output | 6 | Sequencer positions, 3 bits per channel, channel 0 in bits 2:0 |
| len_active | output | 2 | Length-active flag per channel, channel 0 in bit 0 |
| pcm_out | output | 8 | PCM output level |
| out_changed | output | 1 | One-cycle strobe: a sequencer stepped or a PCM register was written |

## Verification
The timer counter cannot be observed at the ports, so its phase after a period change is unknown. The hardest claim to check is the exact spacing of sequencer steps for a period that uses the high bits of the 11-bit period. The stimulus first ticks until the sequencer moves, which aligns it to a reload. It then counts ticks between nine successive moves. The count must be 2*(period+1) each time, and the run crosses the wrap from 7 to 0. The length paths are reached by ordering enable, control and load writes so that the clear, the halt hold and the load-blocked-when-disabled cases each appear at the length-active output.

// File: rtl/xaud_pkg.sv
package xaud_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int PER_W    = 11;
  localparam int LEN_W    = 5;
  localparam int SEQ_W    = 3;
  localparam int NCH      = 2;
  localparam int HALT_BIT = 5;

  localparam logic [ADDR_W-1:0] WIN_BASE   = 16'h5000;
  localparam logic [ADDR_W-1:0] PCM_CTL_AD = 16'h5010;
  localparam logic [ADDR_W-1:0] PCM_AMP_AD = 16'h5011;
  localparam logic [ADDR_W-1:0] LEN_EN_AD  = 16'h5015;
  localparam int CH_STRIDE = 4;

  typedef struct packed {
    logic ctl;
    logic lo;
    logic hi;
  } chan_wr_t;
endpackage

// File: rtl/xaud_decode.sv
module xaud_decode
  import xaud_pkg::*;
#(
  parameter int N_CH = NCH,
  parameter int AW   = ADDR_W
) (
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  output chan_wr_t [N_CH-1:0]     ch_wr,
  output logic                    pcm_ctl_wr,
  output logic                    pcm_amp_wr,
  output logic                    len_en_wr
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [AW-1:0] CH_BASE = AW'(WIN_BASE) + AW'(CH_STRIDE * i);
    assign ch_wr[i].ctl = wr_en && (wr_addr == CH_BASE);
    assign ch_wr[i].lo  = wr_en && (wr_addr == CH_BASE + AW'(2));
    assign ch_wr[i].hi  = wr_en && (wr_addr == CH_BASE + AW'(3));
  end

  assign pcm_ctl_wr = wr_en && (wr_addr == AW'(PCM_CTL_AD));
  assign pcm_amp_wr = wr_en && (wr_addr == AW'(PCM_AMP_AD));
  assign len_en_wr  = wr_en && (wr_addr == AW'(LEN_EN_AD));
endmodule

// File: rtl/xaud_pcm.sv
module xaud_pcm
  import xaud_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic          amp_wr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] pcm_out
);
  logic          en_q;
  logic [DW-1:0] amp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      amp_q   <= '0;
      pcm_out <= '0;
    end else if (ctl_wr) begin
      en_q    <= ~wr_data[0];
      pcm_out <= wr_data[0] ? '0 : amp_q;
    end else if (amp_wr) begin
      amp_q   <= wr_data;
      pcm_out <= en_q ? wr_data : '0;
    end
  end

  assert_pcm_off_R5: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (pcm_out == '0));
  assert_pcm_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr || amp_wr) |=> $stable(pcm_out));
endmodule

// File: rtl/xaud_sq_chan.sv
module xaud_sq_chan
  import xaud_pkg::*;
#(
  parameter int PW  = PER_W,
  parameter int LW  = LEN_W,
  parameter int SW  = SEQ_W,
  parameter int DW  = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          len_clk,
  input  logic          len_en,
  input  logic          len_clr,
  input  chan_wr_t      wr,
  input  logic [DW-1:0] wr_data,
  output logic [SW-1:0] seq,
  output logic          len_active,
  output logic          step
);
  localparam int TW   = PW + 2;
  localparam int HI_W = PW - DW;

  logic [PW-1:0] period_q;
  logic          halt_q;
  logic [TW-1:0] tmr_q;
  logic [LW-1:0] len_q;
  logic [TW-1:0] reload;

  assign reload = {({1'b0, period_q} + (PW+1)'(1)), 1'b0};
  assign step   = tick && (tmr_q == TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      halt_q   <= 1'b0;
    end else begin
      if (wr.lo)  period_q[DW-1:0]  <= wr_data;
      if (wr.hi)  period_q[PW-1:DW] <= wr_data[HI_W-1:0];
      if (wr.ctl) halt_q            <= wr_data[HALT_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        tmr_q <= TW'(1);
    else if (step)  tmr_q <= reload;
    else if (tick)  tmr_q <= tmr_q - TW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)         seq <= '0;
    else if (wr.hi)  seq <= '0;
    else if (step)   seq <= seq + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                                   len_q <= '0;
    else if (len_clr)                          len_q <= '0;
    else if (wr.hi && len_en)                  len_q <= wr_data[DW-1 -: LW];
    else if (len_clk && len_q != '0 && !halt_q) len_q <= len_q - LW'(1);
  end

  assign len_active = (len_q != '0);

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !wr.hi) |=> (seq == $past(seq) + SW'(1)));
  assert_tmr_dec_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && tmr_q != TW'(1)) |=> (tmr_q == $past(tmr_q) - TW'(1)));
  assert_tmr_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    tmr_q != '0);
  assert_len_off_R7: assert property (@(posedge clk) disable iff (rst)
    !len_en |-> (len_q == '0));
  assert_seq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    wr.hi |=> (seq == '0));
  assert_len_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !wr.hi && !len_clr) |=> (len_q == $past(len_q)));
endmodule

// File: rtl/xaud_unit.sv
module xaud_unit
  import xaud_pkg::*;
#(
  parameter int N_CH = NCH,
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int PW   = PER_W,
  parameter int LW   = LEN_W,
  parameter int SW   = SEQ_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               apu_tick,
  input  logic               len_clk,
  output logic [N_CH*SW-1:0] seq_pos,
  output logic [N_CH-1:0]    len_active,
  output logic [DW-1:0]      pcm_out,
  output logic               out_changed
);
  chan_wr_t [N_CH-1:0] ch_wr;
  logic                pcm_ctl_wr, pcm_amp_wr, len_en_wr;
  logic [N_CH-1:0]     len_en_q;
  logic [N_CH-1:0]     step;

  xaud_decode #(.N_CH(N_CH), .AW(AW)) u_dec (
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .ch_wr      (ch_wr),
    .pcm_ctl_wr (pcm_ctl_wr),
    .pcm_amp_wr (pcm_amp_wr),
    .len_en_wr  (len_en_wr)
  );

  always_ff @(posedge clk) begin
    if (rst)            len_en_q <= '0;
    else if (len_en_wr) len_en_q <= wr_data[N_CH-1:0];
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    xaud_sq_chan #(.PW(PW), .LW(LW), .SW(SW), .DW(DW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .tick       (apu_tick),
      .len_clk    (len_clk),
      .len_en     (len_en_q[i]),
      .len_clr    (len_en_wr && !wr_data[i]),
      .wr         (ch_wr[i]),
      .wr_data    (wr_data),
      .seq        (seq_pos[i*SW +: SW]),
      .len_active (len_active[i]),
      .step       (step[i])
    );
  end

  xaud_pcm #(.DW(DW)) u_pcm (
    .clk     (clk),
    .rst     (rst),
    .ctl_wr  (pcm_ctl_wr),
    .amp_wr  (pcm_amp_wr),
    .wr_data (wr_data),
    .pcm_out (pcm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) out_changed <= 1'b0;
    else     out_changed <= (|step) || pcm_ctl_wr || pcm_amp_wr;
  end

  assert_low_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < AW'(WIN_BASE)) |-> !(pcm_ctl_wr || pcm_amp_wr || len_en_wr || (|ch_wr)));
  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !((|step) || pcm_ctl_wr || pcm_amp_wr) |=> !out_changed);
  assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ch_wr, pcm_ctl_wr, pcm_amp_wr, len_en_wr}));
endmodule

// File: tb/xaud_unit_tb.sv
module xaud_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        apu_tick = 1'b0;
  logic        len_clk = 1'b0;
  logic [5:0]  seq_pos;
  logic [1:0]  len_active;
  logic [7:0]  pcm_out;
  logic        out_changed;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xaud_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .apu_tick(apu_tick), .len_clk(len_clk), .seq_pos(seq_pos),
    .len_active(len_active), .pcm_out(pcm_out), .out_changed(out_changed)
  );

  // Vector: {address, data, expected pcm_out, expected len_active}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {16'h5011, 8'h40, 8'h00, 2'b00},  // R6: amp stored while disabled
    {16'h5010, 8'h00, 8'h40, 2'b00},  // R5: bit0=0 enables
    {16'h5011, 8'h7F, 8'h7F, 2'b00},  // R6: amp update while enabled
    {16'h5010, 8'h01, 8'h00, 2'b00},  // R5: bit0=1 disables
    {16'h5011, 8'h22, 8'h00, 2'b00},  // R6: disabled stays 0
    {16'h4011, 8'h00, 8'h00, 2'b00},  // R1: below window
    {16'h5010, 8'hFE, 8'h22, 2'b00},  // R5: only bit0 matters
    {16'h5015, 8'h03, 8'h22, 2'b00},  // R7: enables, counts still 0
    {16'h5003, 8'h28, 8'h22, 2'b01},  // R8: ch0 loads 5
    {16'h5007, 8'hF8, 8'h22, 2'b11},  // R8: ch1 loads 31
    {16'h5001, 8'hFF, 8'h22, 2'b11},  // R1: sweep slot
    {16'h5015, 8'h02, 8'h22, 2'b10},  // R7: ch0 cleared at once
    {16'h5003, 8'h08, 8'h22, 2'b10},  // R8: disabled, no load
    {16'h5015, 8'h00, 8'h22, 2'b00}   // R7: ch1 cleared
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); apu_tick = 1'b1;
    @(negedge clk); apu_tick = 1'b0;
  endtask

  task automatic len_pulse();
    @(negedge clk); len_clk = 1'b1;
    @(negedge clk); len_clk = 1'b0;
  endtask

  function automatic logic [2:0] seq_of(input int ch);
    return seq_pos[ch*3 +: 3];
  endfunction

  task automatic measure(input int ch, input int exp_iv, input string req);
    logic [2:0] prev;
    int n;
    prev = seq_of(ch);
    n = 0;
    while (seq_of(ch) == prev && n < 6000) begin do_tick(); n++; end
    for (int s = 0; s < 9; s++) begin
      prev = seq_of(ch);
      n = 0;
      while (seq_of(ch) == prev && n < 6000) begin do_tick(); n++; end
      chk(n == exp_iv, req, n, exp_iv);
      chk(seq_of(ch) == 3'(prev + 3'd1), "R3 wrap", int'(seq_of(ch)), int'(3'(prev + 3'd1)));
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4: reset state
    chk(seq_pos == '0, "R4 seq", int'(seq_pos), 0);
    chk(len_active == '0, "R4 len", int'(len_active), 0);
    chk(pcm_out == '0, "R4 pcm", int'(pcm_out), 0);
    chk(out_changed == 1'b0, "R4 strobe", int'(out_changed), 0);
    // R4: first tick steps both channels; R11 strobe
    do_tick();
    chk(seq_pos == 6'b001_001, "R4 first tick", int'(seq_pos), 9);
    chk(out_changed == 1'b1, "R11 step strobe", int'(out_changed), 1);
    @(negedge clk);
    chk(out_changed == 1'b0, "R11 strobe drop", int'(out_changed), 0);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][33:18], VEC[v][17:10]);
      chk(pcm_out == VEC[v][9:2], "R5/R6 pcm vector", int'(pcm_out), int'(VEC[v][9:2]));
      chk(len_active == VEC[v][1:0], "R7/R8 len vector", int'(len_active), int'(VEC[v][1:0]));
    end

    // R11: PCM write strobes, sweep slot does not (R1)
    wr(16'h5011, 8'h55);
    chk(out_changed == 1'b1, "R11 pcm strobe", int'(out_changed), 1);
    chk(pcm_out == 8'h55, "R6 amp", int'(pcm_out), 85);
    wr(16'h5005, 8'hFF);
    chk(out_changed == 1'b0, "R1 sweep no strobe", int'(out_changed), 0);
    wr(16'h5012, 8'h01);
    chk(pcm_out == 8'h55 && out_changed == 1'b0, "R1 unassigned", int'(pcm_out), 85);

    // R8: sequencer reset on third register write
    do_tick(); do_tick(); do_tick();
    wr(16'h5003, 8'h00);
    chk(seq_of(0) == 3'd0, "R8 seq clear", int'(seq_of(0)), 0);

    // R3 / R2: step spacing, with high period bits
    wr(16'h5002, 8'h03);
    wr(16'h5003, 8'h00);
    measure(0, 8, "R3 period 3");
    wr(16'h5006, 8'h01);
    wr(16'h5007, 8'h01);
    measure(1, 516, "R2 period 257");

    // R9 / R10: length decrement and halt
    wr(16'h5015, 8'h03);
    wr(16'h5000, 8'h00);
    wr(16'h5003, 8'h10);
    chk(len_active[0] == 1'b1, "R10 active at 2", int'(len_active[0]), 1);
    len_pulse();
    chk(len_active[0] == 1'b1, "R9 count 1", int'(len_active[0]), 1);
    len_pulse();
    chk(len_active[0] == 1'b0, "R10 count 0", int'(len_active[0]), 0);
    len_pulse();
    chk(len_active[0] == 1'b0, "R9 stays 0", int'(len_active[0]), 0);
    wr(16'h5000, 8'h20);
    wr(16'h5003, 8'h08);
    len_pulse(); len_pulse();
    chk(len_active[0] == 1'b1, "R9 halt hold", int'(len_active[0]), 1);
    wr(16'h5000, 8'hDF);
    len_pulse();
    chk(len_active[0] == 1'b0, "R9 unhalted", int'(len_active[0]), 0);
    wr(16'h5004, 8'h20);
    wr(16'h5007, 8'h08);
    len_pulse();
    chk(len_active[1] == 1'b1, "R9 ch1 halt", int'(len_active[1]), 1);
    wr(16'h5004, 8'h00);
    len_pulse();
    chk(len_active == 2'b00, "R9 ch1 drained", int'(len_active), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule